// File: doc/BRIEF.md
# Linear Sensor Line Readout Sequencer

This block runs one scan line of a three-colour linear image sensor. On an accepted line-start request it holds both shift-register clock groups quiet for a guard interval. It then raises the transfer-gate level for a programmable number of clocks and keeps the clocks quiet for a second guard interval. After that it steps through the pixel periods of the line. Each pixel carries its position in the line and a region tag that marks it as dummy, optical black, invalid or valid.

Three resolution modes are supported, and each has its own region map. The full mode reads every position of the fine map. The half mode reads only the odd or only the even positions of that same map. The quarter mode reads the coarse map. The block drives the resolution-select output. It also decides which clock group is actively read and which is flushed, meaning it is clocked so that its charge drains through the reset gate. In half mode it asks for a lengthened reset pulse. Analog sampling, clock edge shaping and colour-line spacing are handled elsewhere.

Top module: `line_scan_seq`

## Requirements
- R1: After reset the transfer gate is low, the pixel index is 0, the region tag is 0 (none), line-done, select and reset-stretch are low, the coarse clock group is enabled (flushing) and the fine group is disabled.
- R2: A line-start request is taken only while no line is active, including the cycle in which line-done is high. The mode, the parity choice and the gate length are captured when the request is taken, so later changes to them, and any request during a line, have no effect on that line. The mode code is 0 for full, 1 for half and 2 for quarter; code 3 behaves as full.
- R3: The gate length in clocks is the requested value clamped to the range TG_MIN..TG_MAX, and a request of 0 selects TG_DEF.
- R4: After a request is taken, both clock enables are low for GUARD_CYC clocks. The gate is then high for the captured length, and both enables stay low for GUARD_CYC clocks after the gate falls.
- R5: In full mode the indices 1..N run in steps of 1. The region codes are: dummy=1 for the first F_DUMMY positions, optical black=2 for the next F_OBLK, invalid=3 for the next F_INV, valid=4 for the next F_VALID, and invalid=3 for the final F_TRAIL.
- R6: In quarter mode the indices run the same way over the coarse map, which uses Q_DUMMY, Q_OBLK, Q_INV, Q_VALID and Q_TRAIL with the same region codes.
- R7: In half mode the indices are those of the full map in steps of 2. They start at 1 when the parity input is 1 (odd) and at 2 when it is 0 (even), and each index is tagged with its full-map region.
- R8: Each pixel index is held for PIX_CYC clocks, and the index and its region tag change in the same cycle.
- R9: The select output is high while the captured mode is quarter and low otherwise.
- R10: The active group (coarse in quarter mode, fine otherwise) is enabled only during pixel readout. The other group is enabled whenever the block is idle or reading out.
- R11: The reset-stretch output is high while the captured mode is half.
- R12: Line-done is high for exactly one clock, in the cycle after the last pixel period. In that cycle the index returns to 0 and the region tag to none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Request to read one line |
| mode_sel | input | 2 | Resolution mode: 0 full, 1 half, 2 quarter |
| odd_pick | input | 1 | Half mode parity: 1 odd, 0 even |
| gate_len | input | GW | Requested gate length in clocks, 0 for default |
| tg_out | output | 1 | Transfer-gate level |
| res_sel | output | 1 | Resolution select, high in quarter mode |
| fine_clk_en | output | 1 | Enable for the fine shift-register clock group |
| coarse_clk_en | output | 1 | Enable for the coarse shift-register clock group |
| reset_stretch | output | 1 | Request for a lengthened reset pulse |
| pix_idx | output | IW | Current pixel position, 0 when not reading |
| pix_region | output | 3 | Region tag of the current pixel |
| line_done | output | 1 | One-clock end-of-line strobe |

## Verification
A new line-start request can land in the same cycle that line-done is asserted, so the end of one line and the acceptance of the next fall together. The bench provokes this by raising the request at the sample where the end strobe shows, and by changing the mode and gate length in that same cycle. It then judges the following line cycle by cycle against its computed timeline: quiet window, gate length, clock routing and every pixel index and tag. A request made in the middle of a line, together with changed mode inputs, must leave that line unchanged and must not start a line after the strobe.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [1:0] {
        MD_FULL = 2'd0,
        MD_HALF = 2'd1,
        MD_QTR  = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_DUMMY   = 3'd1,
        RG_OBLACK  = 3'd2,
        RG_INVALID = 3'd3,
        RG_VALID   = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_GATE = 3'd2,
        ST_POST = 3'd3,
        ST_READ = 3'd4
    } seq_state_e;

endpackage

// File: rtl/lss_gate_clamp.sv
module lss_gate_clamp #(
    parameter int GW     = 16,
    parameter int TG_MIN = 625,
    parameter int TG_DEF = 1250,
    parameter int TG_MAX = 6250
) (
    input  logic [GW-1:0] len_i,
    output logic [GW-1:0] len_o
);
    localparam logic [GW-1:0] L_MIN = GW'(TG_MIN);
    localparam logic [GW-1:0] L_DEF = GW'(TG_DEF);
    localparam logic [GW-1:0] L_MAX = GW'(TG_MAX);

    always_comb begin
        if (len_i == '0)        len_o = L_DEF;
        else if (len_i < L_MIN) len_o = L_MIN;
        else if (len_i > L_MAX) len_o = L_MAX;
        else                    len_o = len_i;
    end
endmodule

// File: rtl/lss_region_map.sv
module lss_region_map
    import lss_pkg::*;
#(
    parameter int IW      = 14,
    parameter int F_DUMMY = 46,
    parameter int F_OBLK  = 100,
    parameter int F_INV   = 8,
    parameter int F_VALID = 10680,
    parameter int F_TRAIL = 8,
    parameter int Q_DUMMY = 12,
    parameter int Q_OBLK  = 25,
    parameter int Q_INV   = 2,
    parameter int Q_VALID = 2670,
    parameter int Q_TRAIL = 2
) (
    input  logic [IW-1:0] idx,
    input  mode_e         mode,
    output region_e       region
);
    // Cumulative upper bounds of each region
    localparam logic [IW-1:0] F1 = IW'(F_DUMMY);
    localparam logic [IW-1:0] F2 = IW'(F_DUMMY + F_OBLK);
    localparam logic [IW-1:0] F3 = IW'(F_DUMMY + F_OBLK + F_INV);
    localparam logic [IW-1:0] F4 = IW'(F_DUMMY + F_OBLK + F_INV + F_VALID);
    localparam logic [IW-1:0] F5 = IW'(F_DUMMY + F_OBLK + F_INV + F_VALID + F_TRAIL);
    localparam logic [IW-1:0] Q1 = IW'(Q_DUMMY);
    localparam logic [IW-1:0] Q2 = IW'(Q_DUMMY + Q_OBLK);
    localparam logic [IW-1:0] Q3 = IW'(Q_DUMMY + Q_OBLK + Q_INV);
    localparam logic [IW-1:0] Q4 = IW'(Q_DUMMY + Q_OBLK + Q_INV + Q_VALID);
    localparam logic [IW-1:0] Q5 = IW'(Q_DUMMY + Q_OBLK + Q_INV + Q_VALID + Q_TRAIL);

    function automatic region_e classify(
        input logic [IW-1:0] i,
        input logic [IW-1:0] b1, input logic [IW-1:0] b2, input logic [IW-1:0] b3,
        input logic [IW-1:0] b4, input logic [IW-1:0] b5);
        if (i == '0)      return RG_NONE;
        else if (i <= b1) return RG_DUMMY;
        else if (i <= b2) return RG_OBLACK;
        else if (i <= b3) return RG_INVALID;
        else if (i <= b4) return RG_VALID;
        else if (i <= b5) return RG_INVALID;
        else              return RG_NONE;
    endfunction

    always_comb begin
        if (mode == MD_QTR) region = classify(idx, Q1, Q2, Q3, Q4, Q5);
        else                region = classify(idx, F1, F2, F3, F4, F5);
    end
endmodule

// File: rtl/lss_clk_route.sv
module lss_clk_route
    import lss_pkg::*;
(
    input  seq_state_e st,
    input  mode_e      mode,
    output logic       fine_en,
    output logic       coarse_en
);
    logic active_run;
    logic flush_run;

    always_comb begin
        active_run = (st == ST_READ);
        flush_run  = (st == ST_READ) || (st == ST_IDLE);
        if (mode == MD_QTR) begin
            coarse_en = active_run;
            fine_en   = flush_run;
        end else begin
            fine_en   = active_run;
            coarse_en = flush_run;
        end
    end
endmodule

// File: rtl/line_scan_seq.sv
module line_scan_seq
    import lss_pkg::*;
#(
    parameter int PIX_CYC   = 4,
    parameter int GUARD_CYC = 125,
    parameter int TG_MIN    = 625,
    parameter int TG_DEF    = 1250,
    parameter int TG_MAX    = 6250,
    parameter int GW        = 16,
    parameter int IW        = 14,
    parameter int F_DUMMY   = 46,
    parameter int F_OBLK    = 100,
    parameter int F_INV     = 8,
    parameter int F_VALID   = 10680,
    parameter int F_TRAIL   = 8,
    parameter int Q_DUMMY   = 12,
    parameter int Q_OBLK    = 25,
    parameter int Q_INV     = 2,
    parameter int Q_VALID   = 2670,
    parameter int Q_TRAIL   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [1:0]    mode_sel,
    input  logic          odd_pick,
    input  logic [GW-1:0] gate_len,
    output logic          tg_out,
    output logic          res_sel,
    output logic          fine_clk_en,
    output logic          coarse_clk_en,
    output logic          reset_stretch,
    output logic [IW-1:0] pix_idx,
    output logic [2:0]    pix_region,
    output logic          line_done
);
    localparam int F_TOTAL = F_DUMMY + F_OBLK + F_INV + F_VALID + F_TRAIL;
    localparam int Q_TOTAL = Q_DUMMY + Q_OBLK + Q_INV + Q_VALID + Q_TRAIL;
    localparam int M1      = (TG_MAX > GUARD_CYC) ? TG_MAX : GUARD_CYC;
    localparam int CNT_MAX = (M1 > PIX_CYC) ? M1 : PIX_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [IW-1:0] LAST_FULL = IW'(F_TOTAL);
    localparam logic [IW-1:0] LAST_QTR  = IW'(Q_TOTAL);
    localparam logic [IW-1:0] LAST_ODD  = IW'((F_TOTAL % 2 == 1) ? F_TOTAL : F_TOTAL - 1);
    localparam logic [IW-1:0] LAST_EVEN = IW'((F_TOTAL % 2 == 0) ? F_TOTAL : F_TOTAL - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          tg;
        logic          done;
        mode_e         md;
        logic          odd;
        logic [GW-1:0] glen;
    } seq_t;

    localparam seq_t R_INIT = '{st: ST_IDLE, cnt: '0, idx: '0, tg: 1'b0, done: 1'b0,
                                md: MD_FULL, odd: 1'b1, glen: GW'(TG_DEF)};

    seq_t r_d, r_q;
    logic [GW-1:0] glen_eff;
    logic [IW-1:0] first_idx, step_idx, last_idx;
    region_e       region_w;

    lss_gate_clamp #(.GW(GW), .TG_MIN(TG_MIN), .TG_DEF(TG_DEF), .TG_MAX(TG_MAX)) u_clamp (
        .len_i (gate_len),
        .len_o (glen_eff)
    );

    lss_region_map #(
        .IW(IW), .F_DUMMY(F_DUMMY), .F_OBLK(F_OBLK), .F_INV(F_INV), .F_VALID(F_VALID),
        .F_TRAIL(F_TRAIL), .Q_DUMMY(Q_DUMMY), .Q_OBLK(Q_OBLK), .Q_INV(Q_INV),
        .Q_VALID(Q_VALID), .Q_TRAIL(Q_TRAIL)
    ) u_map (
        .idx    (r_q.idx),
        .mode   (r_q.md),
        .region (region_w)
    );

    lss_clk_route u_route (
        .st        (r_q.st),
        .mode      (r_q.md),
        .fine_en   (fine_clk_en),
        .coarse_en (coarse_clk_en)
    );

    // Walk parameters for the captured mode
    always_comb begin
        first_idx = IW'(1);
        step_idx  = IW'(1);
        last_idx  = LAST_FULL;
        if (r_q.md == MD_QTR) begin
            last_idx = LAST_QTR;
        end else if (r_q.md == MD_HALF) begin
            step_idx  = IW'(2);
            first_idx = r_q.odd ? IW'(1) : IW'(2);
            last_idx  = r_q.odd ? LAST_ODD : LAST_EVEN;
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (line_start) begin
                    r_d.st   = ST_PRE;
                    r_d.cnt  = CW'(GUARD_CYC - 1);
                    r_d.md   = (mode_sel == 2'd3) ? MD_FULL : mode_e'(mode_sel);
                    r_d.odd  = odd_pick;
                    r_d.glen = glen_eff;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_GATE;
                    r_d.tg  = 1'b1;
                    r_d.cnt = CW'(r_q.glen - GW'(1));
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_GATE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_POST;
                    r_d.tg  = 1'b0;
                    r_d.cnt = CW'(GUARD_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_POST: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_READ;
                    r_d.idx = first_idx;
                    r_d.cnt = CW'(PIX_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            ST_READ: begin
                if (r_q.cnt == '0) begin
                    if (r_q.idx == last_idx) begin
                        r_d.st   = ST_IDLE;
                        r_d.idx  = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + step_idx;
                        r_d.cnt = CW'(PIX_CYC - 1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            default: r_d = R_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= R_INIT;
        else        r_q <= r_d;
    end

    assign tg_out        = r_q.tg;
    assign res_sel       = (r_q.md == MD_QTR);
    assign reset_stretch = (r_q.md == MD_HALF);
    assign pix_idx       = r_q.idx;
    assign pix_region    = region_w;
    assign line_done     = r_q.done;

    // Clocks are quiet in the cycle before the gate rises (R4)
    p_quiet_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tg_out) |-> $past(!fine_clk_en && !coarse_clk_en));

    // Clocks are still quiet as the gate falls (R4)
    p_quiet_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tg_out) |-> (!fine_clk_en && !coarse_clk_en));

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tg_out |-> (r_q.glen >= GW'(TG_MIN) && r_q.glen <= GW'(TG_MAX)));

    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ && $past(r_q.st) == ST_READ && pix_idx != $past(pix_idx))
        |-> (pix_idx == $past(pix_idx) + step_idx));

    p_region_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ) |-> (pix_region != 3'd0));

    p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && $past(r_q.st) != ST_IDLE) |-> $stable(res_sel));

    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    p_done_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (pix_idx == '0 && !tg_out));
endmodule

// File: tb/sim_line_scan_seq.sv
module sim_line_scan_seq;
    localparam int P   = 2;
    localparam int G   = 2;
    localparam int TMN = 3;
    localparam int TDF = 5;
    localparam int TMX = 9;
    localparam int FD = 4, FO = 6, FI = 2, FV = 10, FT = 2;
    localparam int QD = 2, QO = 3, QI = 1, QV = 5, QT = 1;
    localparam int FTOT = FD + FO + FI + FV + FT;
    localparam int QTOT = QD + QO + QI + QV + QT;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode_i;
    logic        odd_i;
    logic [15:0] glen_i;
    logic        tg, sel, fine_en, coarse_en, rst_str, done;
    logic [13:0] idx;
    logic [2:0]  region;

    int n_tests = 0;
    int n_fail  = 0;
    bit pre_started = 1'b0;

    always #4 clk = ~clk;

    line_scan_seq #(
        .PIX_CYC(P), .GUARD_CYC(G), .TG_MIN(TMN), .TG_DEF(TDF), .TG_MAX(TMX),
        .GW(16), .IW(14),
        .F_DUMMY(FD), .F_OBLK(FO), .F_INV(FI), .F_VALID(FV), .F_TRAIL(FT),
        .Q_DUMMY(QD), .Q_OBLK(QO), .Q_INV(QI), .Q_VALID(QV), .Q_TRAIL(QT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_start(start), .mode_sel(mode_i),
        .odd_pick(odd_i), .gate_len(glen_i), .tg_out(tg), .res_sel(sel),
        .fine_clk_en(fine_en), .coarse_clk_en(coarse_en), .reset_stretch(rst_str),
        .pix_idx(idx), .pix_region(region), .line_done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int g);
        if (g == 0)   return TDF;
        if (g < TMN)  return TMN;
        if (g > TMX)  return TMX;
        return g;
    endfunction

    function automatic int ref_region(input int m, input int i);
        int b1, b2, b3, b4, b5;
        if (m == 2) begin
            b1 = QD; b2 = b1 + QO; b3 = b2 + QI; b4 = b3 + QV; b5 = b4 + QT;
        end else begin
            b1 = FD; b2 = b1 + FO; b3 = b2 + FI; b4 = b3 + FV; b5 = b4 + FT;
        end
        if (i <= 0)  return 0;
        if (i <= b1) return 1;
        if (i <= b2) return 2;
        if (i <= b3) return 3;
        if (i <= b4) return 4;
        if (i <= b5) return 3;
        return 0;
    endfunction

    task automatic run_line(input int m_in, input bit odd, input int g, input bit mid_start,
                            input bit chain, input int nm, input bit nodd, input int ng);
        int m, len, step, first, total, np, nsamp, ph, p, eidx, act_en, flu_en, tg_seen;
        string mtag;
        m     = (m_in == 1) ? 1 : ((m_in == 2) ? 2 : 0);
        mtag  = (m == 0) ? "R5/R8" : ((m == 2) ? "R6/R8" : "R7/R8");
        len   = eff_len(g);
        step  = (m == 1) ? 2 : 1;
        first = (m == 1 && !odd) ? 2 : 1;
        total = (m == 2) ? QTOT : FTOT;
        np    = 0;
        for (int i = first; i <= total; i += step) np++;
        nsamp   = 2 * G + len + np * P + 1;
        tg_seen = 0;
        if (!pre_started) begin
            @(negedge clk);
            mode_i = 2'(m_in); odd_i = odd; glen_i = 16'(g); start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        pre_started = 1'b0;
        for (int n = 0; n < nsamp; n++) begin
            if (n > 0) @(negedge clk);
            if (mid_start && n == 3) begin
                start = 1'b1; mode_i = (m == 2) ? 2'd0 : 2'd2; odd_i = ~odd; glen_i = 16'd1;
            end
            if (mid_start && n == 4) start = 1'b0;
            if (n < G)                  ph = 0;
            else if (n < G + len)       ph = 1;
            else if (n < 2 * G + len)   ph = 2;
            else if (n < nsamp - 1)     ph = 3;
            else                        ph = 4;
            p    = (ph == 3) ? (n - 2 * G - len) / P : 0;
            eidx = (ph == 3) ? first + step * p : 0;
            if (tg) tg_seen++;
            act_en = (m == 2) ? int'(coarse_en) : int'(fine_en);
            flu_en = (m == 2) ? int'(fine_en) : int'(coarse_en);
            chk(tg == (ph == 1), "R4 gate level", int'(tg), int'(ph == 1));
            chk(act_en == int'(ph == 3), "R10/R4 active group enable", act_en, int'(ph == 3));
            chk(flu_en == int'(ph == 3 || ph == 4), "R10/R4 flushed group enable", flu_en,
                int'(ph == 3 || ph == 4));
            chk(int'(idx) == eidx, {mtag, " pixel index"}, int'(idx), eidx);
            chk(int'(region) == ref_region(m, eidx), {mtag, " region tag"}, int'(region),
                ref_region(m, eidx));
            chk(sel == (m == 2), "R9 select", int'(sel), int'(m == 2));
            chk(rst_str == (m == 1), "R11 reset stretch", int'(rst_str), int'(m == 1));
            chk(done == (ph == 4), "R12 line done", int'(done), int'(ph == 4));
            if (chain && n == nsamp - 1) begin
                mode_i = 2'(nm); odd_i = nodd; glen_i = 16'(ng); start = 1'b1;
                pre_started = 1'b1;
            end
        end
        chk(tg_seen == len, "R3 gate length", tg_seen, len);
        if (!chain) begin
            repeat (4) begin
                @(negedge clk);
                chk(!tg && idx == 0 && !done, "R2 no line after ignored request", int'(tg), 0);
                chk(flu_en == 1 && act_en == 0, "R10 idle routing", flu_en, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int gl[4];
        gl = '{0, 1, 7, 20};
        rst_n = 1'b0; start = 1'b0; mode_i = 2'd0; odd_i = 1'b1; glen_i = 16'd0;
        repeat (3) @(negedge clk);
        chk(!tg && idx == 0 && region == 0, "R1 reset gate/index/tag", int'(idx), 0);
        chk(!done && !sel && !rst_str, "R1 reset strobes", int'(done), 0);
        chk(coarse_en && !fine_en, "R1 reset routing", int'(coarse_en), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tg && idx == 0, "R1 idle after release", int'(tg), 0);

        // Sweep mode, parity and gate length (R3, R5, R6, R7)
        for (int m = 0; m < 3; m++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++)
                    run_line(m, p[0], gl[k], 1'b0, 1'b0, 0, 1'b0, 0);

        // Reserved mode code behaves as full (R2)
        run_line(3, 1'b1, 5, 1'b0, 1'b0, 0, 1'b0, 0);
        // Request and input changes during a line are ignored (R2)
        run_line(0, 1'b1, 0, 1'b1, 1'b0, 0, 1'b0, 0);
        run_line(1, 1'b0, 6, 1'b1, 1'b0, 0, 1'b0, 0);
        // Request in the line-done cycle starts the next line (R2, R12)
        run_line(2, 1'b0, 4, 1'b0, 1'b1, 1, 1'b0, 6);
        run_line(1, 1'b0, 6, 1'b0, 1'b1, 0, 1'b1, 9);
        run_line(0, 1'b1, 9, 1'b0, 1'b0, 0, 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule